// File: doc/BRIEF.md
# Latch-Slaved Stopped-Clock Ladder DAC Loader

This block feeds a two-channel ladder DAC that runs in simultaneous mode, where one latch-enable pulse moves both channel words from the input shift registers onto the ladder switches. The latch is a plain divided-down copy of the master clock. A free-running divider sets the latch rate, and the divide ratio comes from a requested sample-rate code. The loader is slaved to that latch. When latch enable falls, it takes one stereo sample from an upstream ready/valid source. It then shifts the two words out MSB first on two data lines that share one bit clock running at half the master rate. After the last bit it holds the bit clock low and freezes the data lines. The DAC pins therefore stay still for the rest of the period, and the latch edge lands in a quiet interval.

The rate code also drives a select output that chooses between the two oscillator families, one for 44.1 kHz multiples and one for 48 kHz multiples. Some ratios leave no room for a quiet interval before the next latch. For those ratios the block raises a configuration-error flag and does no loading, but the latch keeps running. If no sample is offered when latch enable falls, the block sends the last accepted sample again and flags an underrun for that period.

Top module: `scdac_loader`

## Requirements
- R1: The latch period is `MAX_RATIO >> rate_code[1:0]` master cycles (128, 64, 32 or 16 by default). In every period `dac_le` is high for exactly `LE_HIGH` cycles at the start and low for the rest.
- R2: `fam_sel` equals `rate_code[2]`: 0 selects the 44.1 kHz family, 1 selects the 48 kHz family.
- R3: `rate_code` is sampled only at a period boundary. A change in the middle of a period alters neither that period's length nor `fam_sel` until the next latch rising edge.
- R4: In a valid configuration, each falling edge of `dac_le` starts a load. The load gives exactly `WORD_W` rising edges of `dac_bck`. The left word goes out on `dac_dl` and the right word on `dac_dr`, both MSB first and in parallel.
- R5: `dac_dl` and `dac_dr` change only while `dac_bck` is low, so they are stable at every rising edge of the bit clock.
- R6: After the last bit, `dac_bck` stays low. At least `GUARD` master cycles with no bit-clock edge pass before the next `dac_le` rising edge, and `dac_bck` is never high while `dac_le` is high.
- R7: `cfg_err` is 1 whenever the current ratio is below `LE_HIGH + 2*WORD_W + GUARD`. This covers ratios 32 and 16 by default. In such a period the bit clock produces no edge and no sample is accepted.
- R8: If `s_valid` is low when a load starts, the last accepted sample is sent again and `underrun` is 1 from the cycle after the start until the next load start. A load with a valid sample, or a load slot that falls inside an errored configuration, clears `underrun`.
- R9: `s_ready` is a single-cycle pulse in the first cycle with `dac_le` low, and only when `cfg_err` is 0.
- R10: While `rst_n` is low, `dac_le`, `dac_bck`, `dac_dl`, `dac_dr`, `s_ready`, `underrun`, `cfg_err` and `fam_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock from the selected oscillator |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | RATE_W | Top bit picks the family; low bits pick a divide shift |
| s_valid | input | 1 | Upstream sample present |
| s_ready | output | 1 | Sample taken this cycle |
| s_left | input | WORD_W | Left-channel sample word |
| s_right | input | WORD_W | Right-channel sample word |
| dac_le | output | 1 | Latch enable to the DAC |
| dac_bck | output | 1 | Gated bit clock to the DAC |
| dac_dl | output | 1 | Left serial data |
| dac_dr | output | 1 | Right serial data |
| fam_sel | output | 1 | Oscillator family select |
| cfg_err | output | 1 | Ratio too short for stopped-clock loading |
| underrun | output | 1 | Current load re-sent the held sample |

## Verification
Most internal faults in this block show up at the DAC pins within one latch period. If the divider is off by one, the spacing between latch rising edges changes, and so does the fam_sel timing. If the loader's bit counter is wrong, a period ends with a number of bit-clock rising edges other than sixteen, or with a captured word that is shifted. A stray data-update phase moves a data line while the bit clock is high. A bad stop condition puts bit-clock edges inside the guard window or under a high latch. A wrong hold register shows up only one period after the underrun, as the wrong word sent again.

// File: rtl/scdl_pkg.sv
`timescale 1ns/1ps
package scdl_pkg;
   typedef enum logic {
      LD_IDLE  = 1'b0,
      LD_SHIFT = 1'b1
   } ld_state_t;
endpackage

// File: rtl/scdl_latch_div.sv
`timescale 1ns/1ps
module scdl_latch_div #(
   parameter int MAX_RATIO = 128,
   parameter int RATE_W    = 3,
   parameter int LE_HIGH   = 2,
   parameter int LOAD_SPAN = 38,
   parameter int CNT_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_code,
   output logic              le,
   output logic              fam,
   output logic              bad_cfg,
   output logic              start
);
   localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_RATIO);
   localparam logic [CNT_W-1:0] HI_C   = CNT_W'(LE_HIGH);
   localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(LOAD_SPAN);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ratio_q;
   logic [CNT_W-1:0] ratio_n;
   logic [CNT_W-1:0] cnt_inc;
   logic             wrap;

   assign ratio_n = MAX_C >> rate_code[RATE_W-2:0];
   assign cnt_inc = cnt_q + ONE_C;
   assign wrap    = (cnt_q == ratio_q - ONE_C);
   assign start   = (cnt_q == HI_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= MAX_C - ONE_C;
         ratio_q <= MAX_C;
         le      <= 1'b0;
         fam     <= 1'b0;
         bad_cfg <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         ratio_q <= ratio_n;
         fam     <= rate_code[RATE_W-1];
         bad_cfg <= (ratio_n < SPAN_C);
         le      <= 1'b1;
      end else begin
         cnt_q <= cnt_inc;
         le    <= (cnt_inc < HI_C);
      end
   end
endmodule

// File: rtl/scdl_sample_hold.sv
`timescale 1ns/1ps
module scdl_sample_hold #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              en,
   input  logic              s_valid,
   input  logic [WORD_W-1:0] s_left,
   input  logic [WORD_W-1:0] s_right,
   output logic              s_ready,
   output logic [WORD_W-1:0] word_l,
   output logic [WORD_W-1:0] word_r,
   output logic              underrun
);
   logic [WORD_W-1:0] hold_l;
   logic [WORD_W-1:0] hold_r;

   assign s_ready = start & en;
   assign word_l  = s_valid ? s_left  : hold_l;
   assign word_r  = s_valid ? s_right : hold_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l   <= '0;
         hold_r   <= '0;
         underrun <= 1'b0;
      end else if (start) begin
         if (en) begin
            underrun <= ~s_valid;
            if (s_valid) begin
               hold_l <= s_left;
               hold_r <= s_right;
            end
         end else begin
            underrun <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/scdl_shifter.sv
`timescale 1ns/1ps
module scdl_shifter
   import scdl_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NCH    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [NCH-1:0][WORD_W-1:0] words,
   output logic                       bck,
   output logic [NCH-1:0]             dat
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_C = BIT_W'(WORD_W - 1);

   ld_state_t        st;
   logic             ph;
   logic [BIT_W-1:0] bidx;
   logic             advance;

   assign advance = (st == LD_SHIFT) && ph && (bidx != LAST_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LD_IDLE;
         ph   <= 1'b0;
         bidx <= '0;
         bck  <= 1'b0;
      end else if (load) begin
         st   <= LD_SHIFT;
         ph   <= 1'b0;
         bidx <= '0;
         bck  <= 1'b0;
      end else if (st == LD_SHIFT) begin
         if (!ph) begin
            bck <= 1'b1;
            ph  <= 1'b1;
         end else begin
            bck <= 1'b0;
            ph  <= 1'b0;
            if (bidx == LAST_C) st <= LD_IDLE;
            else                bidx <= bidx + 1'b1;
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      logic [WORD_W-1:0] sh;
      logic              bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh    <= '0;
            bit_q <= 1'b0;
         end else if (load) begin
            bit_q <= words[c][WORD_W-1];
            sh    <= words[c] << 1;
         end else if (advance) begin
            bit_q <= sh[WORD_W-1];
            sh    <= sh << 1;
         end
      end
      assign dat[c] = bit_q;
   end
endmodule

// File: rtl/scdac_loader.sv
`timescale 1ns/1ps
module scdac_loader #(
   parameter int WORD_W    = 16,
   parameter int MAX_RATIO = 128,
   parameter int RATE_W    = 3,
   parameter int LE_HIGH   = 2,
   parameter int GUARD     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_left,
   input  logic [WORD_W-1:0] s_right,
   output logic              dac_le,
   output logic              dac_bck,
   output logic              dac_dl,
   output logic              dac_dr,
   output logic              fam_sel,
   output logic              cfg_err,
   output logic              underrun
);
   localparam int NCH       = 2;
   localparam int CNT_W     = $clog2(MAX_RATIO) + 1;
   localparam int LOAD_SPAN = LE_HIGH + 2 * WORD_W + GUARD;
   localparam int MIN_RATIO = MAX_RATIO >> ((2 ** (RATE_W - 1)) - 1);

   if (RATE_W < 2) begin : g_chk_rate
      $error("rate code needs a family bit and a shift field");
   end
   if ((MAX_RATIO & (MAX_RATIO - 1)) != 0) begin : g_chk_pow2
      $error("MAX_RATIO must be a power of two");
   end
   if (MIN_RATIO < LE_HIGH + 2) begin : g_chk_min
      $error("shortest ratio leaves no low phase for a load start");
   end
   if (MAX_RATIO < LOAD_SPAN) begin : g_chk_span
      $error("no ratio can hold a full load and guard");
   end
   if (LE_HIGH < 1 || WORD_W < 2) begin : g_chk_misc
      $error("LE_HIGH and WORD_W out of range");
   end

   logic                       start;
   logic                       bad_cfg;
   logic [WORD_W-1:0]          word_l;
   logic [WORD_W-1:0]          word_r;
   logic [NCH-1:0][WORD_W-1:0] words;
   logic [NCH-1:0]             dat;

   scdl_latch_div #(
      .MAX_RATIO(MAX_RATIO), .RATE_W(RATE_W), .LE_HIGH(LE_HIGH),
      .LOAD_SPAN(LOAD_SPAN), .CNT_W(CNT_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .rate_code(rate_code),
      .le(dac_le), .fam(fam_sel), .bad_cfg(bad_cfg), .start(start)
   );

   scdl_sample_hold #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(start), .en(~bad_cfg),
      .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
      .s_ready(s_ready), .word_l(word_l), .word_r(word_r),
      .underrun(underrun)
   );

   assign words[0] = word_l;
   assign words[1] = word_r;

   scdl_shifter #(.WORD_W(WORD_W), .NCH(NCH)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(s_ready), .words(words),
      .bck(dac_bck), .dat(dat)
   );

   assign dac_dl  = dat[0];
   assign dac_dr  = dat[1];
   assign cfg_err = bad_cfg;
endmodule

// File: rtl/scdl_checker.sv
`timescale 1ns/1ps
module scdl_checker #(
   parameter int WORD_W  = 16,
   parameter int LE_HIGH = 2
) (
   input logic clk,
   input logic rst_n,
   input logic dac_le,
   input logic dac_bck,
   input logic dac_dl,
   input logic dac_dr,
   input logic fam_sel,
   input logic cfg_err,
   input logic s_ready,
   input logic underrun
);
   logic       le_q;
   logic       bck_q;
   logic [7:0] hi_cnt;
   logic [7:0] rises;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         le_q   <= 1'b0;
         bck_q  <= 1'b0;
         hi_cnt <= '0;
         rises  <= '0;
      end else begin
         le_q   <= dac_le;
         bck_q  <= dac_bck;
         hi_cnt <= dac_le ? hi_cnt + 1'b1 : '0;
         if (dac_le && !le_q)         rises <= '0;
         else if (dac_bck && !bck_q)  rises <= rises + 1'b1;
      end
   end

   assert_latch_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_le && le_q) |-> (hi_cnt == 8'(LE_HIGH)));

   assert_rate_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(fam_sel) || !$stable(cfg_err)) |-> (dac_le && !le_q));

   assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_le && !le_q) |-> (rises == 8'd0 || rises == 8'(WORD_W)));

   assert_data_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dac_dl) || !$stable(dac_dr)) |-> !dac_bck);

   assert_bck_low_in_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_le |-> !dac_bck);

   assert_cfg_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!dac_bck && !s_ready));

   assert_underrun_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(underrun) |-> (!dac_le && !le_q));

   assert_ready_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (!dac_le && le_q));
endmodule

bind scdac_loader scdl_checker #(.WORD_W(WORD_W), .LE_HIGH(LE_HIGH)) u_scdl_checker (
   .clk(clk), .rst_n(rst_n), .dac_le(dac_le), .dac_bck(dac_bck),
   .dac_dl(dac_dl), .dac_dr(dac_dr), .fam_sel(fam_sel), .cfg_err(cfg_err),
   .s_ready(s_ready), .underrun(underrun)
);

// File: tb/test_scdac_loader.sv
`timescale 1ns/1ps
module test_scdac_loader;
   localparam int W     = 16;
   localparam int GUARD = 4;
   localparam int SPAN  = 2 + 2 * W + GUARD;

   typedef struct packed {
      logic [2:0]   code;
      logic [W-1:0] l;
      logic [W-1:0] r;
      logic         v;
      logic         ur;
      logic [W-1:0] el;
      logic [W-1:0] er;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'hA5C3, 16'h5A3C, 1'b1, 1'b0, 16'hA5C3, 16'h5A3C},
      '{3'd1, 16'h8001, 16'h7FFE, 1'b1, 1'b0, 16'h8001, 16'h7FFE},
      '{3'd4, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'hFFFF, 16'h0000},
      '{3'd5, 16'h1234, 16'hABCD, 1'b0, 1'b1, 16'hFFFF, 16'h0000},
      '{3'd2, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 16'h0000, 16'h0000},
      '{3'd6, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 16'h0000, 16'h0000},
      '{3'd3, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 16'h0000, 16'h0000},
      '{3'd7, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 16'h0000, 16'h0000},
      '{3'd0, 16'h0001, 16'h8000, 1'b1, 1'b0, 16'h0001, 16'h8000},
      '{3'd5, 16'h4444, 16'h2222, 1'b0, 1'b1, 16'h0001, 16'h8000}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   rate_code = 3'd0;
   logic         s_valid = 1'b0;
   logic [W-1:0] s_left = '0;
   logic [W-1:0] s_right = '0;
   logic         s_ready, dac_le, dac_bck, dac_dl, dac_dr, fam_sel, cfg_err, underrun;

   int n_chk = 0;
   int n_bad = 0;

   scdac_loader i_scdac_loader (
      .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .s_valid(s_valid),
      .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .dac_le(dac_le),
      .dac_bck(dac_bck), .dac_dl(dac_dl), .dac_dr(dac_dr), .fam_sel(fam_sel),
      .cfg_err(cfg_err), .underrun(underrun)
   );

   always #5 clk = ~clk;

   // port monitor, sampled on the falling master edge
   int           cyc = 0, nrise = 0, last_edge = 0, rise_prev = 0, nrise_prev = 0;
   int           per_len = 0, rises = 0, quiet = 0;
   int           dchg_bad = 0, le_bad = 0, rdy_bad = 0, rdy_cnt = 0;
   logic [W-1:0] cap_l = '0, cap_r = '0;
   logic         bck_p = 1'b0, le_p = 1'b0, dl_p = 1'b0, dr_p = 1'b0;
   event         ev_rise;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (dac_bck && !bck_p) begin
            nrise = nrise + 1;
            cap_l = {cap_l[W-2:0], dac_dl};
            cap_r = {cap_r[W-2:0], dac_dr};
         end
         if (dac_bck != bck_p) last_edge = cyc;
         if (((dac_dl != dl_p) || (dac_dr != dr_p)) && dac_bck) dchg_bad = dchg_bad + 1;
         if (dac_le && dac_bck) le_bad = le_bad + 1;
         if (s_ready) begin
            rdy_cnt = rdy_cnt + 1;
            if (!(le_p && !dac_le) || cfg_err) rdy_bad = rdy_bad + 1;
         end
         if (dac_le && !le_p) begin
            per_len    = cyc - rise_prev;
            rises      = nrise - nrise_prev;
            quiet      = cyc - last_edge;
            rise_prev  = cyc;
            nrise_prev = nrise;
            ->ev_rise;
         end
      end
      bck_p = dac_bck; le_p = dac_le; dl_p = dac_dl; dr_p = dac_dr;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset state
      check("R10 le",  dac_le,   0);
      check("R10 bck", dac_bck,  0);
      check("R10 dat", {dac_dl, dac_dr}, 0);
      check("R10 rdy", s_ready,  0);
      check("R10 ur",  underrun, 0);
      check("R10 err", cfg_err,  0);
      check("R10 fam", fam_sel,  0);
      rst_n = 1'b1;
      @(ev_rise);

      for (int i = 0; i < NV; i++) begin
         int   ratio;
         logic err;
         ratio = 128 >> VECS[i].code[1:0];
         err   = (ratio < SPAN);
         rate_code = VECS[i].code;
         s_valid   = VECS[i].v;
         s_left    = VECS[i].l;
         s_right   = VECS[i].r;
         @(ev_rise);
         @(ev_rise);
         check("R1 period", per_len, ratio);
         check("R2 family", fam_sel, VECS[i].code[2]);
         check("R7 cfg_err", cfg_err, err);
         check(err ? "R7 no bck edges" : "R4 bck rises", rises, err ? 0 : W);
         check("R8 underrun", underrun, err ? 0 : VECS[i].ur);
         if (!err) begin
            check("R4 left word",  cap_l, VECS[i].el);
            check("R4 right word", cap_r, VECS[i].er);
            check("R6 guard", (quiet >= GUARD) ? 1 : 0, 1);
         end
      end

      // R3: rate change inside a period waits for the boundary
      rate_code = 3'd0;
      @(ev_rise);
      check("R3 old ratio kept", per_len, 64);
      @(ev_rise);
      check("R3 new ratio", per_len, 128);
      repeat (10) @(negedge clk);
      rate_code = 3'd5;
      @(ev_rise);
      check("R3 mid-period change", per_len, 128);
      check("R3 family at boundary", fam_sel, 1);
      @(ev_rise);
      check("R3 applied", per_len, 64);

      check("R5 data moved under high bck", dchg_bad, 0);
      check("R6 bck high during latch", le_bad, 0);
      check("R9 ready timing", rdy_bad, 0);
      check("R9 ready seen", (rdy_cnt > 0) ? 1 : 0, 1);
      finish_run();
   end
endmodule